// File: doc/BRIEF.md
# Translation Lookaside Buffer with Access Permission Checking

This block is a small, fully associative cache of page table entries. It sits between a processor's virtual address and the memory system. For each lookup it compares the virtual page number against every stored entry in parallel, in the same cycle. When a stored entry matches, the block returns the physical address at once, with no page table fetch. It builds that address by joining the stored physical page number to the untranslated page offset.

Each stored entry keeps the permission bits of the page table entry: readable, writable and supervisor-only. A matching lookup is checked against the access kind (read or write) and the current privilege (user or supervisor). A lookup that finds an entry can therefore end in a protection fault instead of a translation.

When no entry matches, the block reports a miss. An external page table walker then fetches the entry and presents it on the refill port. The block installs it in the lowest-numbered empty slot. If no slot is empty, it installs it in the slot named by a round-robin pointer. A flush input empties the whole buffer in one cycle, for use when the page table base changes.

Top module: `tlb_perm`

## Requirements
- R1: After reset every slot is empty and the round-robin pointer is 0, so any lookup reports miss=1, hit=0, prot_fault=0, paddr=0.
- R2: A lookup whose page number (lk_vaddr[31:12]) matches a stored entry, and whose access the permissions allow, reports hit=1 in the same cycle, with paddr = {stored physical page number, lk_vaddr[11:0]}.
- R3: A lookup whose page number matches no stored entry reports miss=1 and paddr=0 in the same cycle. Whenever hit=0, paddr is 0.
- R4: A matching lookup with lk_user=1 (user mode) to an entry whose supervisor-only bit is 1 reports prot_fault=1, hit=0 and paddr=0.
- R5: A matching lookup with lk_write=1 to an entry whose writable bit is 0 reports prot_fault=1. So does a matching lookup with lk_write=0 to an entry whose readable bit is 0.
- R6: An accepted refill, made while at least one slot is empty, goes into the lowest-numbered empty slot and evicts no stored entry.
- R7: An accepted refill made while every slot is full replaces the slot named by the round-robin pointer. The pointer then advances by one, wrapping from 7 to 0, so successive refills evict entries in the order they were installed.
- R8: flush=1 empties every slot at the next clock edge and returns the pointer to 0. A refill presented in the same cycle is dropped.
- R9: A refill whose page number already matches a stored entry is ignored. The stored translation is unchanged, and no slot is written or evicted.
- R10: At most one of hit, miss and prot_fault is 1, and all three are 0 while lk_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access kind: 1 write, 0 read |
| lk_user | input | 1 | Privilege: 1 user mode, 0 supervisor mode |
| rf_valid | input | 1 | Refill entry presented by the walker |
| rf_vpn | input | 20 | Virtual page number of the refill |
| rf_ppn | input | 20 | Physical page number of the refill |
| rf_rd | input | 1 | Refill entry is readable |
| rf_wr | input | 1 | Refill entry is writable |
| rf_sup | input | 1 | Refill entry is supervisor-only |
| flush | input | 1 | Empty every slot at the next edge |
| hit | output | 1 | Lookup translated and access allowed |
| miss | output | 1 | Lookup found no stored entry |
| prot_fault | output | 1 | Lookup found an entry that forbids the access |
| paddr | output | 32 | Physical address; 0 unless hit |

## Verification
The assertions take for granted that lookup inputs stay stable across each rising edge. They also take for granted that the stored entries never hold two copies of one page number. The duplicate filter on the refill port (R9) is what keeps that second condition true.

The bench changes every input just after a falling edge, so lookups are stable through each rising edge. It offers duplicate refills only to show that they are rejected. Its sweeps fill all eight slots with page numbers chosen to be distinct, one slot for each of the eight permission combinations. Each slot is then probed under every pairing of access kind and privilege, and eviction order is followed through full wraps of the pointer.

// File: rtl/tlb_perm_pkg.sv
// Shared types for the translation buffer: permission bits of a stored
// entry and the rule that decides whether an access is allowed.
package tlb_perm_pkg;

    // Permission bits kept with each stored entry.
    typedef struct packed {
        logic rd;   // page may be read
        logic wr;   // page may be written
        logic sup;  // page is for supervisor mode only
    } perm_t;

    // True when an access of the given kind and privilege is allowed.
    function automatic logic perm_allows(perm_t p, logic is_write, logic is_user);
        logic kind_ok;
        kind_ok = is_write ? p.wr : p.rd;
        return kind_ok && !(is_user && p.sup);
    endfunction

endpackage

// File: rtl/tlb_store.sv
// Entry storage: valid bits, page numbers and permissions for N slots.
// Assumes the caller writes at most one slot per cycle. Flush overrides
// any write presented in the same cycle.
module tlb_store
    import tlb_perm_pkg::*;
#(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [VPN_W-1:0]          wr_vpn,
    input  logic [PPN_W-1:0]          wr_ppn,
    input  perm_t                     wr_perm,
    output logic [N-1:0]              valid_vec,
    output logic [N-1:0][VPN_W-1:0]   vpn_arr,
    output logic [N-1:0][PPN_W-1:0]   ppn_arr,
    output perm_t [N-1:0]             perm_arr
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            // Valid bit of one slot: cleared by reset or flush, set when written.
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    valid_vec[g] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    valid_vec[g] <= 1'b1;
                end
            end

            // Payload of one slot: loaded on a write, no reset needed.
            always_ff @(posedge clk) begin
                if (wr_en && !flush && (wr_idx == IDX_W'(g))) begin
                    vpn_arr[g]  <= wr_vpn;
                    ppn_arr[g]  <= wr_ppn;
                    perm_arr[g] <= wr_perm;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tlb_cam.sv
// Parallel page number compare against all valid slots. Returns whether
// any slot matched and the index of the matching slot. Assumes there is
// at most one match; if there were more, the lowest index would win.
module tlb_cam #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             valid_vec,
    input  logic [N-1:0][VPN_W-1:0]  vpn_arr,
    input  logic [VPN_W-1:0]         key,
    output logic                     found,
    output logic [IDX_W-1:0]         idx
);

    logic [N-1:0] match;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign match[g] = valid_vec[g] && (vpn_arr[g] == key);
        end
    endgenerate

    // Priority encode the match vector, lowest index first.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign found = |match;

endmodule

// File: rtl/tlb_victim.sv
// Slot choice for a refill: the lowest empty slot if there is one,
// otherwise the round-robin pointer. The pointer moves only when a refill
// is accepted while every slot is full. Flush returns it to 0.
module tlb_victim #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic [N-1:0]      valid_vec,
    output logic [IDX_W-1:0]  victim_idx
);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Find the lowest empty slot.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign victim_idx = any_free ? free_idx : rr_ptr;

    // Round-robin pointer: advance after each replacement into a full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rr_ptr <= '0;
        end else if (alloc && !any_free) begin
            rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_perm.sv
// Fully associative translation buffer with permission checking.
// Lookup is combinational: hit, miss, prot_fault and paddr follow the
// lookup inputs in the same cycle. Refill and flush take effect at the
// clock edge. A refill whose page number is already stored is dropped, so
// the lookup compare never sees two matches.
module tlb_perm
    import tlb_perm_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 32,
    parameter int OFS_W   = 12,
    parameter int PPN_W   = 20,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int PA_W   = PPN_W + OFS_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_write,
    input  logic              lk_user,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic              rf_rd,
    input  logic              rf_wr,
    input  logic              rf_sup,
    input  logic              flush,
    output logic              hit,
    output logic              miss,
    output logic              prot_fault,
    output logic [PA_W-1:0]   paddr
);

    logic [ENTRIES-1:0]             valid_vec;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_arr;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_arr;
    perm_t [ENTRIES-1:0]            perm_arr;

    logic              lk_found;
    logic [IDX_W-1:0]  lk_idx;
    logic              rf_dup;
    logic [IDX_W-1:0]  rf_dup_idx;
    logic [IDX_W-1:0]  victim_idx;
    logic              rf_accept;
    perm_t             rf_perm;
    perm_t             sel_perm;
    logic [PPN_W-1:0]  sel_ppn;
    logic              access_ok;

    assign rf_perm   = '{rd: rf_rd, wr: rf_wr, sup: rf_sup};
    assign rf_accept = rf_valid && !flush && !rf_dup;

    tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (rf_accept),
        .wr_idx    (victim_idx),
        .wr_vpn    (rf_vpn),
        .wr_ppn    (rf_ppn),
        .wr_perm   (rf_perm),
        .valid_vec (valid_vec),
        .vpn_arr   (vpn_arr),
        .ppn_arr   (ppn_arr),
        .perm_arr  (perm_arr)
    );

    tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W)) u_cam_lookup (
        .valid_vec (valid_vec),
        .vpn_arr   (vpn_arr),
        .key       (lk_vaddr[VA_W-1:OFS_W]),
        .found     (lk_found),
        .idx       (lk_idx)
    );

    tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W)) u_cam_refill (
        .valid_vec (valid_vec),
        .vpn_arr   (vpn_arr),
        .key       (rf_vpn),
        .found     (rf_dup),
        .idx       (rf_dup_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .alloc      (rf_accept),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );

    // Select the fields of the matching slot.
    always_comb begin
        sel_perm = perm_arr[lk_idx];
        sel_ppn  = ppn_arr[lk_idx];
    end

    assign access_ok = perm_allows(sel_perm, lk_write, lk_user);

    // Lookup outcome; the address is driven only on an allowed hit.
    always_comb begin
        hit        = lk_valid && lk_found && access_ok;
        miss       = lk_valid && !lk_found;
        prot_fault = lk_valid && lk_found && !access_ok;
        paddr      = hit ? {sel_ppn, lk_vaddr[OFS_W-1:0]} : '0;
    end

    // The refill-side match index is only needed as a presence flag.
    logic unused_dup_idx;
    assign unused_dup_idx = ^rf_dup_idx;

endmodule

// File: rtl/tlb_perm_chk.sv
// Property checker for tlb_perm, attached by bind. It relates the lookup
// outputs to the lookup inputs and to the permissions of the selected slot.
module tlb_perm_chk
    import tlb_perm_pkg::*;
#(
    parameter int OFS_W = 12,
    parameter int PA_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_write,
    input logic              lk_user,
    input logic [OFS_W-1:0]  lk_ofs,
    input logic              flush,
    input perm_t             sel_perm,
    input logic              hit,
    input logic              miss,
    input logic              prot_fault,
    input logic [PA_W-1:0]   paddr
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit, miss, prot_fault}));                                  // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(hit || miss || prot_fault));                         // R10

    AST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (paddr == '0));                                             // R3

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (paddr[OFS_W-1:0] == lk_ofs));                               // R2

    AST_USER_NO_SUP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && lk_user) |-> !sel_perm.sup);                                 // R4

    AST_WRITE_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && lk_write) |-> sel_perm.wr);                                  // R5

    AST_READ_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !lk_write) |-> sel_perm.rd);                                 // R5

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && lk_valid) |-> miss);                                // R8

endmodule

bind tlb_perm tlb_perm_chk #(.OFS_W(OFS_W), .PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_write   (lk_write),
    .lk_user    (lk_user),
    .lk_ofs     (lk_vaddr[OFS_W-1:0]),
    .flush      (flush),
    .sel_perm   (sel_perm),
    .hit        (hit),
    .miss       (miss),
    .prot_fault (prot_fault),
    .paddr      (paddr)
);

// File: tb/tlb_perm_test.sv
// Bench for tlb_perm. It holds a reference model of slot contents and the
// replacement pointer, derived from the requirements, and sweeps lookups
// over every slot, access kind and privilege.
module tlb_perm_test;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [19:0] rf_ppn = '0;
    logic        rf_rd = 1'b0;
    logic        rf_wr = 1'b0;
    logic        rf_sup = 1'b0;
    logic        flush = 1'b0;
    logic        hit, miss, prot_fault;
    logic [31:0] paddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state.
    bit        m_valid [N];
    bit [19:0] m_vpn   [N];
    bit [19:0] m_ppn   [N];
    bit [2:0]  m_perm  [N];   // {sup, wr, rd}
    int        m_ptr;

    always #10 clk = ~clk;    // 50 MHz

    tlb_perm uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .lk_user(lk_user), .rf_valid(rf_valid),
        .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_rd(rf_rd), .rf_wr(rf_wr),
        .rf_sup(rf_sup), .flush(flush), .hit(hit), .miss(miss),
        .prot_fault(prot_fault), .paddr(paddr)
    );

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        m_ptr = 0;
    endtask

    // One clock of refill and/or flush, with the model updated to match.
    task automatic refill(input bit [19:0] vpn, input bit [19:0] ppn,
                          input bit [2:0] perm, input bit with_flush);
        bit dup;
        int slot;
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn;
        rf_rd = perm[0]; rf_wr = perm[1]; rf_sup = perm[2];
        flush = with_flush;
        @(negedge clk);
        rf_valid = 1'b0; flush = 1'b0;
        if (with_flush) begin
            model_clear();
        end else begin
            dup = 0;
            for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == vpn) dup = 1;
            if (!dup) begin
                slot = -1;
                for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
                if (slot < 0) begin
                    slot = m_ptr;
                    m_ptr = (m_ptr + 1) % N;
                end
                m_valid[slot] = 1; m_vpn[slot] = vpn;
                m_ppn[slot] = ppn; m_perm[slot] = perm;
            end
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_clear();
    endtask

    // Present a lookup and compare all outputs with the model's prediction.
    task automatic lookup(input bit [31:0] va, input bit wr, input bit user,
                          input string req);
        bit e_hit, e_miss, e_flt, found, ok;
        bit [31:0] e_pa;
        bit [2:0] pm;
        bit [19:0] pp;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_user = user;
        #1;
        found = 0; pm = '0; pp = '0;
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == va[31:12]) begin
                found = 1; pm = m_perm[i]; pp = m_ppn[i];
            end
        ok = (wr ? pm[1] : pm[0]) && !(user && pm[2]);
        e_hit = found && ok;
        e_miss = !found;
        e_flt = found && !ok;
        e_pa = e_hit ? {pp, va[11:0]} : 32'h0;
        checks++;
        if (hit !== e_hit || miss !== e_miss || prot_fault !== e_flt || paddr !== e_pa) begin
            errors++;
            $display("FAIL %s: va=%h wr=%0d user=%0d got h/m/f=%b%b%b pa=%h exp %b%b%b pa=%h",
                     req, va, wr, user, hit, miss, prot_fault, paddr,
                     e_hit, e_miss, e_flt, e_pa);
        end
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    function automatic bit [19:0] vpn_of(int k);
        return 20'h01000 + 20'(k * 37);
    endfunction

    function automatic bit [19:0] ppn_of(int k);
        return 20'hA5000 ^ 20'(k * 4099);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    string tag;

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset.
        lookup(32'h0000_0123, 0, 0, "R1");
        lookup({vpn_of(0), 12'h456}, 1, 1, "R1");

        // R10: idle lookup port gives no outcome.
        @(negedge clk); #1;
        checks++;
        if (hit || miss || prot_fault || paddr != 0) begin
            errors++;
            $display("FAIL R10: idle got h/m/f=%b%b%b pa=%h exp 000 pa=0",
                     hit, miss, prot_fault, paddr);
        end

        // R6: fill all slots, one per permission combination.
        for (int k = 0; k < N; k++) refill(vpn_of(k), ppn_of(k), 3'(k), 0);

        // R2 R4 R5: every slot under every access kind and privilege.
        for (int k = 0; k < N; k++)
            for (int a = 0; a < 4; a++) begin
                if (a[1] && k[2]) tag = "R4";
                else if (!(a[0] ? k[1] : k[0])) tag = "R5";
                else tag = "R2";
                lookup({vpn_of(k), 12'(k * 111 + a)}, a[0], a[1], tag);
            end

        // R3: unknown page numbers miss.
        for (int k = N; k < N + 4; k++) lookup({vpn_of(k), 12'hFFF}, 0, 0, "R3");

        // R9: duplicate refill neither rewrites nor evicts.
        refill(vpn_of(3), 20'h12345, 3'b011, 0);
        lookup({vpn_of(3), 12'h010}, 0, 0, "R9");
        lookup({vpn_of(0), 12'h020}, 0, 0, "R9");

        // R7: full buffer replaces in install order, through a full wrap.
        for (int k = 0; k < N + 2; k++) begin
            refill(vpn_of(20 + k), ppn_of(20 + k), 3'b011, 0);
            lookup({vpn_of(20 + k), 12'h0AB}, 1, 1, "R7");
            lookup({vpn_of(k < N ? k : 20 + k - N), 12'h0CD}, 0, 0, "R7");
        end

        // R8: flush with a simultaneous refill leaves everything empty.
        refill(vpn_of(50), ppn_of(50), 3'b011, 1);
        lookup({vpn_of(50), 12'h001}, 0, 0, "R8");
        lookup({vpn_of(29), 12'h002}, 0, 0, "R8");

        // R6 R8: refill after flush restarts at slot 0 and pointer 0.
        for (int k = 0; k < N; k++) refill(vpn_of(60 + k), ppn_of(60 + k), 3'b111, 0);
        for (int k = 0; k < N; k++) lookup({vpn_of(60 + k), 12'h333}, 0, 0, "R6");
        refill(vpn_of(70), ppn_of(70), 3'b111, 0);
        lookup({vpn_of(60), 12'h444}, 0, 0, "R8");
        lookup({vpn_of(61), 12'h445}, 0, 1, "R8");

        // R8: plain flush.
        do_flush();
        lookup({vpn_of(70), 12'h555}, 0, 0, "R8");

        finish_run();
    end

endmodule